// File: doc/BRIEF.md
# Routing Table Lookup Unit

The unit keeps a small routing table in on-chip storage and serves three kinds of work. Table writes and table reads share one request queue. Packet lookups arrive on a separate packet queue. Every queue edge uses a valid/ready handshake. A fixed-priority scheduler accepts at most one transaction per cycle. A read returns the stored entry on a reply queue. A lookup takes the low 12 bits of a 32-bit packet word as its key, reads the table entry at that key, and sends the whole packet to one of four output queues. The low two bits of the entry pick the queue.

Lookups pass through three stages. The first stage accepts the packet. The second holds the registered table read. The third places the packet in a small in-order completion buffer. The buffer head is shown on exactly one output queue, so packets leave in arrival order whatever their destinations. A write is held back while a lookup is between its table read and the completion buffer. This keeps the write from landing in the middle of a lookup. A pending write also stops new packets from being accepted, so it cannot be starved.

Top module: `route_lookup`

## Requirements
- R1: After reset every table entry reads as zero, and `rep_valid` and `out_valid` are low.
- R2: A write stores the 12-bit `tbl_wdata` at the 12-bit `tbl_addr`. A read (`tbl_wr`=0) puts the entry on `rep_data` with `rep_valid` high in the cycle after acceptance. The reply holds steady until `rep_ready`.
- R3: A read is not accepted while a reply is waiting with `rep_ready` low.
- R4: At most one request is accepted per cycle, in the order write, then read, then packet. A packet is refused in any cycle where a read is accepted or a write is at the head of the request queue.
- R5: A write is never accepted in the cycle after a packet acceptance. A lookup already in flight uses the table contents from before that write.
- R6: The key of a packet is `pkt_data[11:0]`. The packet goes out unchanged on `out_data`, with `out_valid[q]` high, where q is bits [1:0] of the table entry. It appears two cycles after acceptance at the earliest.
- R7: Packets leave in acceptance order. A blocked head holds back later packets, even those bound for ready queues.
- R8: No more than four accepted packets are held at once; `pkt_ready` stays low while the unit is full.
- R9: At most one bit of `out_valid` is high, and a waiting output keeps its valid bit and data until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_valid | input | 1 | Table request present |
| tbl_ready | output | 1 | Table request accepted |
| tbl_wr | input | 1 | 1 = write, 0 = read |
| tbl_addr | input | 12 | Table address |
| tbl_wdata | input | 12 | Write value |
| rep_valid | output | 1 | Read reply present |
| rep_ready | input | 1 | Reply consumer ready |
| rep_data | output | 12 | Read reply value |
| pkt_valid | input | 1 | Packet present |
| pkt_ready | output | 1 | Packet accepted |
| pkt_data | input | 32 | Packet word, key in low 12 bits |
| out_valid | output | 4 | Per-queue output valid |
| out_ready | input | 4 | Per-queue output ready |
| out_data | output | 32 | Outgoing packet word |

## Verification
The bound checker watches several rules on every cycle. It confirms that only one transaction is accepted per cycle and that a pending write locks out packets. It confirms that no write is accepted right after a packet acceptance and that reads are held off while a reply waits. It also checks that reply and output data stay stable under backpressure and that `out_valid` is one-hot or zero. Some behaviours need the bench's scenarios: the actual table values and the queue each packet is routed to, arrival order across different queues, and the completion buffer filling up. The atomicity scenario shows that a lookup accepted just before a write still routes by the old entry, and that the next lookup uses the new one.

// File: rtl/route_lookup.sv
module route_lookup #(
  parameter int AW       = 12,
  parameter int DW       = 12,
  parameter int PW       = 32,
  parameter int NQ       = 4,
  parameter int CB_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_valid,
  output logic          tbl_ready,
  input  logic          tbl_wr,
  input  logic [AW-1:0] tbl_addr,
  input  logic [DW-1:0] tbl_wdata,
  output logic          rep_valid,
  input  logic          rep_ready,
  output logic [DW-1:0] rep_data,
  input  logic          pkt_valid,
  output logic          pkt_ready,
  input  logic [PW-1:0] pkt_data,
  output logic [NQ-1:0] out_valid,
  input  logic [NQ-1:0] out_ready,
  output logic [PW-1:0] out_data
);
  localparam int DEPTH = 1 << AW;
  localparam int QW    = $clog2(NQ);
  localparam int CBW   = $clog2(CB_DEPTH);
  localparam logic [CBW+1:0] CB_LIM = CB_DEPTH[CBW+1:0];

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] written;

  logic             s1_vld;
  logic [PW-1:0]    s1_pkt;
  logic [DW-1:0]    s1_ent;

  logic [PW-1:0]    cb_pkt [CB_DEPTH];
  logic [QW-1:0]    cb_q   [CB_DEPTH];
  logic [CBW-1:0]   cb_wp, cb_rp;
  logic [CBW:0]     cb_cnt;
  logic [CBW+1:0]   held;

  logic wr_go, rd_go, pk_go, cb_pop, cb_any;
  logic [AW-1:0] key;

  function automatic logic [DW-1:0] entry(input logic [AW-1:0] a);
    return written[a] ? mem[a] : '0;
  endfunction

  assign key    = pkt_data[AW-1:0];
  assign held   = {1'b0, cb_cnt} + {{(CBW+1){1'b0}}, s1_vld};
  assign wr_go  = tbl_valid & tbl_wr & ~s1_vld;
  assign rd_go  = tbl_valid & ~tbl_wr & (~rep_valid | rep_ready);
  assign pk_go  = pkt_valid & ~(tbl_valid & tbl_wr) & ~rd_go & (held < CB_LIM);
  assign tbl_ready = wr_go | rd_go;
  assign pkt_ready = pk_go;

  assign cb_any    = (cb_cnt != '0);
  assign cb_pop    = cb_any & out_ready[cb_q[cb_rp]];
  assign out_valid = cb_any ? ({{(NQ-1){1'b0}}, 1'b1} << cb_q[cb_rp]) : '0;
  assign out_data  = cb_pkt[cb_rp];

  always_ff @(posedge clk)
    if (wr_go) mem[tbl_addr] <= tbl_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     written <= '0;
    else if (wr_go) written[tbl_addr] <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rep_valid <= 1'b0;
      rep_data  <= '0;
    end else if (rd_go) begin
      rep_valid <= 1'b1;
      rep_data  <= entry(tbl_addr);
    end else if (rep_ready) begin
      rep_valid <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_pkt <= '0;
      s1_ent <= '0;
    end else begin
      s1_vld <= pk_go;
      if (pk_go) begin
        s1_pkt <= pkt_data;
        s1_ent <= entry(key);
      end
    end

  always_ff @(posedge clk)
    if (s1_vld) begin
      cb_pkt[cb_wp] <= s1_pkt;
      cb_q[cb_wp]   <= s1_ent[QW-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cb_wp  <= '0;
      cb_rp  <= '0;
      cb_cnt <= '0;
    end else begin
      if (s1_vld) cb_wp <= cb_wp + 1'b1;
      if (cb_pop) cb_rp <= cb_rp + 1'b1;
      cb_cnt <= cb_cnt + {{CBW{1'b0}}, s1_vld} - {{CBW{1'b0}}, cb_pop};
    end
endmodule

// File: rtl/route_lookup_chk.sv
module route_lookup_chk #(
  parameter int AW = 12,
  parameter int DW = 12,
  parameter int PW = 32,
  parameter int NQ = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tbl_valid,
  input logic          tbl_ready,
  input logic          tbl_wr,
  input logic          rep_valid,
  input logic          rep_ready,
  input logic [DW-1:0] rep_data,
  input logic          pkt_valid,
  input logic          pkt_ready,
  input logic [NQ-1:0] out_valid,
  input logic [NQ-1:0] out_ready,
  input logic [PW-1:0] out_data
);
  logic tbl_acc, pkt_acc;
  assign tbl_acc = tbl_valid & tbl_ready;
  assign pkt_acc = pkt_valid & pkt_ready;

  p_one_txn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tbl_acc && pkt_acc));

  p_wr_blocks_pkt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_valid && tbl_wr) |-> !pkt_ready);

  p_drain_before_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_acc |=> !(tbl_acc && tbl_wr));

  p_reply_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_acc && !tbl_wr) |=> rep_valid);

  p_reply_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_data)));

  p_read_held_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |-> !(tbl_acc && !tbl_wr));

  p_out_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & ~out_ready)) |=> (out_valid == $past(out_valid) && $stable(out_data)));
endmodule

bind route_lookup route_lookup_chk #(.AW(AW), .DW(DW), .PW(PW), .NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .tbl_valid(tbl_valid), .tbl_ready(tbl_ready),
  .tbl_wr(tbl_wr), .rep_valid(rep_valid), .rep_ready(rep_ready),
  .rep_data(rep_data), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_route_lookup.sv
module test_route_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_valid = 1'b0, tbl_wr = 1'b0;
  logic [11:0] tbl_addr = '0, tbl_wdata = '0;
  logic        tbl_ready, rep_valid, rep_ready = 1'b1;
  logic [11:0] rep_data;
  logic        pkt_valid = 1'b0, pkt_ready;
  logic [31:0] pkt_data = '0, out_data;
  logic [3:0]  out_valid, out_ready = 4'hF;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  route_lookup i_route_lookup (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_tbl(input logic wr, input logic [11:0] a, input logic [11:0] d);
    @(negedge clk);
    tbl_valid = 1'b1; tbl_wr = wr; tbl_addr = a; tbl_wdata = d;
    #0.1;
    while (!tbl_ready) @(negedge clk);
    @(posedge clk); #1;
    tbl_valid = 1'b0;
  endtask

  task automatic send_pkt(input logic [31:0] p);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_data = p;
    #0.1;
    while (!pkt_ready) @(negedge clk);
    @(posedge clk); #1;
    pkt_valid = 1'b0;
  endtask

  // kind[45:44]: 0 write, 1 read, 2 packet; word[43:12]; value[11:0]
  localparam logic [45:0] VEC [13] = '{
    {2'd0, 32'h0000_0005, 12'h123},
    {2'd0, 32'h0000_0ABC, 12'h7F1},
    {2'd1, 32'h0000_0005, 12'h123},
    {2'd1, 32'h0000_0006, 12'h000},
    {2'd2, 32'hDEAD_0005, 12'h003},
    {2'd2, 32'h1234_5ABC, 12'h001},
    {2'd2, 32'h0F0F_0777, 12'h000},
    {2'd0, 32'h0000_0777, 12'h002},
    {2'd2, 32'h1111_0777, 12'h002},
    {2'd1, 32'h0000_0ABC, 12'h7F1},
    {2'd0, 32'h0000_0FFF, 12'hFFF},
    {2'd1, 32'h0000_0FFF, 12'hFFF},
    {2'd2, 32'h0000_0FFF, 12'h003}
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seen [4];
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rep_valid after reset", {31'd0, rep_valid}, 32'd0);
    chk("R1 out_valid after reset", {28'd0, out_valid}, 32'd0);

    for (int i = 0; i < 13; i++) begin
      logic [1:0]  k;
      logic [31:0] w;
      logic [11:0] v;
      {k, w, v} = VEC[i];
      if (k == 2'd0) send_tbl(1'b1, w[11:0], v);
      else if (k == 2'd1) begin
        send_tbl(1'b0, w[11:0], 12'h0);
        chk("R2/R1 reply valid", {31'd0, rep_valid}, 32'd1);
        chk("R2/R1 reply data", {20'd0, rep_data}, {20'd0, v});
      end else begin
        send_pkt(w);
        chk("R6 no output one cycle after accept", {28'd0, out_valid}, 32'd0);
        @(posedge clk); #1;
        chk("R6 output queue", {28'd0, out_valid}, 32'd1 << v[1:0]);
        chk("R6 output data", out_data, w);
      end
    end
    repeat (3) @(posedge clk);

    // R7/R8: fill with outputs blocked, then check order
    out_ready = 4'h0;
    send_pkt(32'hAAAA_0005);
    send_pkt(32'hBBBB_0ABC);
    send_pkt(32'hCCCC_0777);
    send_pkt(32'hDDDD_0FFF);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_data = 32'hEEEE_0005;
    #0.1;
    chk("R8 full refuses packet", {31'd0, pkt_ready}, 32'd0);
    @(negedge clk);
    chk("R8 still full", {31'd0, pkt_ready}, 32'd0);
    pkt_valid = 1'b0;
    chk("R7 head shown first", {28'd0, out_valid}, 32'h8);
    chk("R7 head data", out_data, 32'hAAAA_0005);
    out_ready = 4'b0010;
    repeat (2) @(negedge clk);
    chk("R7 blocked head holds order", {28'd0, out_valid}, 32'h8);
    chk("R9 data held under backpressure", out_data, 32'hAAAA_0005);
    out_ready = 4'hF;
    n = 0;
    for (int c = 0; c < 6; c++) begin
      #0.1;
      if (|out_valid && n < 4) begin seen[n] = out_data; n++; end
      @(negedge clk);
    end
    chk("R7 count drained", n, 4);
    chk("R7 order 0", seen[0], 32'hAAAA_0005);
    chk("R7 order 1", seen[1], 32'hBBBB_0ABC);
    chk("R7 order 2", seen[2], 32'hCCCC_0777);
    chk("R7 order 3", seen[3], 32'hDDDD_0FFF);

    // R4/R5: priority and drain-before-write
    @(negedge clk);
    pkt_valid = 1'b1; pkt_data = 32'hCAFE_0100;
    tbl_valid = 1'b1; tbl_wr = 1'b1; tbl_addr = 12'h100; tbl_wdata = 12'h003;
    #0.1;
    chk("R4 write beats packet (tbl)", {31'd0, tbl_ready}, 32'd1);
    chk("R4 write beats packet (pkt)", {31'd0, pkt_ready}, 32'd0);
    @(negedge clk);
    tbl_valid = 1'b0;
    #0.1;
    chk("R4 packet goes once write done", {31'd0, pkt_ready}, 32'd1);
    @(negedge clk);
    pkt_valid = 1'b0;
    tbl_valid = 1'b1; tbl_wr = 1'b1; tbl_addr = 12'h100; tbl_wdata = 12'h000;
    #0.1;
    chk("R5 write waits for in-flight lookup", {31'd0, tbl_ready}, 32'd0);
    @(negedge clk);
    chk("R5 in-flight lookup uses old entry", {28'd0, out_valid}, 32'h8);
    chk("R5 in-flight data", out_data, 32'hCAFE_0100);
    chk("R5 write accepted after drain", {31'd0, tbl_ready}, 32'd1);
    @(negedge clk);
    tbl_valid = 1'b0;
    send_pkt(32'hBEEF_0100);
    @(posedge clk); #1;
    chk("R5 later lookup uses new entry", {28'd0, out_valid}, 32'h1);

    // R4: read beats packet
    @(negedge clk);
    pkt_valid = 1'b1; pkt_data = 32'h0000_0005;
    tbl_valid = 1'b1; tbl_wr = 1'b0; tbl_addr = 12'h005;
    #0.1;
    chk("R4 read beats packet", {31'd0, pkt_ready}, 32'd0);
    @(negedge clk);
    tbl_valid = 1'b0;
    chk("R4 read reply", {20'd0, rep_data}, 32'h123);
    #0.1;
    chk("R4 packet after read", {31'd0, pkt_ready}, 32'd1);
    @(negedge clk);
    pkt_valid = 1'b0;
    repeat (3) @(negedge clk);

    // R3: reply backpressure
    rep_ready = 1'b0;
    send_tbl(1'b0, 12'h005, 12'h0);
    @(negedge clk);
    tbl_valid = 1'b1; tbl_wr = 1'b0; tbl_addr = 12'hABC;
    #0.1;
    chk("R3 read held while reply waits", {31'd0, tbl_ready}, 32'd0);
    @(negedge clk);
    chk("R3 still held", {31'd0, tbl_ready}, 32'd0);
    chk("R2 reply held", {20'd0, rep_data}, 32'h123);
    rep_ready = 1'b1;
    #0.1;
    chk("R3 read accepted as reply drains", {31'd0, tbl_ready}, 32'd1);
    @(negedge clk);
    tbl_valid = 1'b0;
    chk("R3 next reply", {20'd0, rep_data}, 32'h7F1);
    chk("R3 next reply valid", {31'd0, rep_valid}, 32'd1);
    repeat (3) @(negedge clk);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule